// File: doc/BRIEF.md
# Control Register Bank with Overwrite, Set, Clear and Toggle Aliases

This block is the register slice that sits between a simple synchronous bus and a peripheral. It holds a group of 32-bit control registers that drive the peripheral, plus a group of status words that the peripheral drives and that the bus can only read. Each register owns a 16-byte slot in the address space. Inside the slot, four word addresses select how a write is applied: the first overwrites, the second ORs the written data in, the third clears the bits written as one and the fourth inverts them. Software can therefore start or stop one channel's enable bit without reading the register first, and without disturbing bits that other code owns.

The bus has no handshake. The address is a word address (byte address divided by four): its two low bits pick the alias and the bits above pick the slot. A write is applied on the rising clock edge on which the write enable is high. Read data is combinational from the current address and shows the stored value whichever alias is addressed. The control registers are exposed on a flat output vector for the peripheral logic.

Top module: `alias_reg_bank`

## Requirements
- R1: After synchronous active-low reset, every control register holds its reset value (parameter, all zero by default), seen both on `ctrl_q` and on `bus_rdata`.
- R2: A write with alias code 0 (`bus_addr[1:0]` = 0, byte offset 0x0) replaces the addressed control register with `bus_wdata`.
- R3: A write with alias code 1 (byte offset 0x4) produces old | wdata: bits written as one become one, bits written as zero keep their value.
- R4: A write with alias code 2 (byte offset 0x8) produces old & ~wdata, so one enable bit can be dropped while the other enable bits stay set.
- R5: A write with alias code 3 (byte offset 0xC) produces old ^ wdata.
- R6: A read at any of the four alias codes of a slot returns the same stored value, in the same cycle the address is presented.
- R7: The slot index is `bus_addr[ADDR_W-1:2]` (16 bytes per register); control register k sits at slot k and a write changes only the addressed register.
- R8: Slots NUM_RW to NUM_RW+NUM_RO-1 are read-only: reads return the matching `stat_in` word and writes at any alias change no control register.
- R9: A write lands on the rising edge where `bus_we` is high; reads in the same cycle still show the old value and the next cycle shows the new one; with `bus_we` low nothing changes.
- R10: Slots beyond the last register read as zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Word address: [1:0] alias code, upper bits slot |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Value of the addressed slot |
| stat_in | input | NUM_RO*DATA_W (32) | Status words shown in the read-only slots |
| ctrl_q | output | NUM_RW*DATA_W (96) | All control registers, register k at bits [k*32 +: 32] |

## Verification
The assertions check on every cycle that each control register follows its alias rule after a write (overwrite, OR, clear, XOR), that it holds when not selected, that it takes its reset value, that at most one register is selected, and that writes to read-only or unmapped slots leave the control vector unchanged. What only the bench's scenarios show is the address map as seen from outside: which slot holds which register, that all four aliases read back the same word in the same cycle, that read-only slots mirror `stat_in`, and that unmapped slots read zero, all compared against a behavioural model on every clock over directed and pseudo-random traffic.

// File: rtl/alias_bank_pkg.sv
// Package alias_bank_pkg
// Shared types for the aliased register bank: the code carried in the two
// low word-address bits that selects how a write is applied.
package alias_bank_pkg;

    typedef enum logic [1:0] {
        ALIAS_WRITE  = 2'd0,
        ALIAS_SET    = 2'd1,
        ALIAS_CLEAR  = 2'd2,
        ALIAS_TOGGLE = 2'd3
    } alias_op_e;

    localparam int ALIAS_BITS = 2;

endpackage

// File: rtl/alias_decode.sv
// Module alias_decode
// Splits a word address into alias code and slot index and produces one
// write select per control register.
// Assumes: NUM_RW <= 2**(ADDR_W-2); slots at or above NUM_RW never select.
module alias_decode
    import alias_bank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_RW = 3,
    localparam int SLOT_W = ADDR_W - ALIAS_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [NUM_RW-1:0] sel,
    output alias_op_e         op,
    output logic [SLOT_W-1:0] slot,
    output logic              rw_hit
);

    // Field split of the word address
    assign op   = alias_op_e'(addr[ALIAS_BITS-1:0]);
    assign slot = addr[ADDR_W-1:ALIAS_BITS];

    // One write select per control register
    for (genvar g = 0; g < NUM_RW; g++) begin : g_sel
        assign sel[g] = we && (slot == SLOT_W'(g));
    end

    // Slot falls on a writable register
    assign rw_hit = (32'(slot) < NUM_RW);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R7

endmodule

// File: rtl/alias_reg_cell.sv
// Module alias_reg_cell
// One writable control register. On a selected write it applies the alias
// rule (overwrite, OR, AND-NOT, XOR) to its own value; otherwise it holds.
// Assumes: synchronous active-low reset to RST_VAL.
module alias_reg_cell
    import alias_bank_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  alias_op_e         op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] nxt;
    logic              seen_rst;

    // Next value for each alias rule
    always_comb begin
        case (op)
            ALIAS_SET:    nxt = q | wdata;
            ALIAS_CLEAR:  nxt = q & ~wdata;
            ALIAS_TOGGLE: nxt = q ^ wdata;
            default:      nxt = wdata;
        endcase
    end

    // Storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL;
        else if (wr_sel) q <= nxt;
    end

    // Marks that a reset has been applied, so history checks are meaningful
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst && !$past(rst_n) |-> q == RST_VAL); // R1
    AST_HOLD_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst && $past(rst_n) && !$past(wr_sel) |-> $stable(q)); // R9
    AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst && $past(rst_n) && $past(wr_sel) && $past(op) == ALIAS_WRITE
        |-> q == $past(wdata)); // R2
    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst && $past(rst_n) && $past(wr_sel) && $past(op) == ALIAS_SET
        |-> ((q & $past(wdata)) == $past(wdata))
            && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R3
    AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst && $past(rst_n) && $past(wr_sel) && $past(op) == ALIAS_CLEAR
        |-> ((q & $past(wdata)) == '0)
            && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))); // R4
    AST_TOGGLE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst && $past(rst_n) && $past(wr_sel) && $past(op) == ALIAS_TOGGLE
        |-> (q ^ $past(q)) == $past(wdata)); // R5

endmodule

// File: rtl/alias_read_mux.sv
// Module alias_read_mux
// Selects the word of the addressed slot from the concatenated register
// values; any slot without a register reads as zero.
// Assumes: NUM_REGS <= 2**SLOT_W.
module alias_read_mux #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int SLOT_W   = 4
) (
    input  logic [NUM_REGS*DATA_W-1:0] vals,
    input  logic [SLOT_W-1:0]          slot,
    output logic [DATA_W-1:0]          rdata
);

    // Combinational slot select with zero default
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (slot == SLOT_W'(i)) rdata = vals[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/alias_reg_bank.sv
// Module alias_reg_bank
// Register slice with four write aliases per 16-byte slot. Slots
// 0..NUM_RW-1 are writable control registers; the next NUM_RO slots show
// the status words from stat_in and ignore writes; higher slots read zero.
// Assumes: single-cycle bus, no handshake, word address on bus_addr.
module alias_reg_bank
    import alias_bank_pkg::*;
#(
    parameter int                       DATA_W   = 32,
    parameter int                       ADDR_W   = 6,
    parameter int                       NUM_RW   = 3,
    parameter int                       NUM_RO   = 1,
    parameter logic [NUM_RW*DATA_W-1:0] RST_VALS = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_RO*DATA_W-1:0]   stat_in,
    output logic [NUM_RW*DATA_W-1:0]   ctrl_q
);

    localparam int SLOT_W   = ADDR_W - ALIAS_BITS;
    localparam int NUM_REGS = NUM_RW + NUM_RO;

    logic [NUM_RW-1:0]          sel;
    alias_op_e                  op;
    logic [SLOT_W-1:0]          slot;
    logic                       rw_hit;
    logic [NUM_REGS*DATA_W-1:0] all_vals;

    alias_decode #(
        .ADDR_W (ADDR_W),
        .NUM_RW (NUM_RW)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .we     (bus_we),
        .sel    (sel),
        .op     (op),
        .slot   (slot),
        .rw_hit (rw_hit)
    );

    // One storage cell per writable register
    for (genvar g = 0; g < NUM_RW; g++) begin : g_cell
        alias_reg_cell #(
            .DATA_W  (DATA_W),
            .RST_VAL (RST_VALS[g*DATA_W +: DATA_W])
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (sel[g]),
            .op     (op),
            .wdata  (bus_wdata),
            .q      (ctrl_q[g*DATA_W +: DATA_W])
        );
    end

    // Status words follow the control registers in the slot order
    assign all_vals = {stat_in, ctrl_q};

    alias_read_mux #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .SLOT_W   (SLOT_W)
    ) u_rmux (
        .vals  (all_vals),
        .slot  (slot),
        .rdata (bus_rdata)
    );

    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !rw_hit |=> $stable(ctrl_q)); // R8
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(ctrl_q)); // R9

endmodule

// File: tb/tb_alias_reg_bank.sv
`timescale 1ns/1ps
module tb_alias_reg_bank;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam int NRW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [DW-1:0]     stat_in = 32'hA5A5_0F0F;
    logic [NRW*DW-1:0] ctrl_q;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] m [NRW];

    always #2.5 clk = ~clk;

    alias_reg_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_in   (stat_in),
        .ctrl_q    (ctrl_q)
    );

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        int s = int'(a[AW-1:2]);
        if (s < NRW) return m[s];
        if (s == NRW) return stat_in;
        return '0;
    endfunction

    function automatic logic [NRW*DW-1:0] model_vec();
        logic [NRW*DW-1:0] v;
        for (int i = 0; i < NRW; i++) v[i*DW +: DW] = m[i];
        return v;
    endfunction

    task automatic check(input string tag, input logic [NRW*DW-1:0] act,
                         input logic [NRW*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare after settling, update model at edge
    task automatic step(input logic [AW-1:0] a, input logic w,
                        input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_wdata = d;
        #1;
        check({tag, " rdata"}, {64'h0, bus_rdata}, {64'h0, model_read(a)});
        check({tag, " ctrl"}, ctrl_q, model_vec());
        @(posedge clk);
        if (w && int'(a[AW-1:2]) < NRW) begin
            case (a[1:0])
                2'd0: m[a[AW-1:2]] = d;
                2'd1: m[a[AW-1:2]] = m[a[AW-1:2]] | d;
                2'd2: m[a[AW-1:2]] = m[a[AW-1:2]] & ~d;
                default: m[a[AW-1:2]] = m[a[AW-1:2]] ^ d;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        for (int i = 0; i < NRW; i++) m[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        do_reset();
        // R1: reset state on every control slot
        for (int s = 0; s < NRW; s++) step(AW'(s * 4), 1'b0, '0, "R1");
        // R2: overwrite, R6 readback at all aliases
        step(6'h00, 1'b1, 32'h1234_5678, "R2");
        for (int k = 0; k < 4; k++) step(AW'(k), 1'b0, '0, "R6");
        // R3: set alias ORs in bits
        step(6'h01, 1'b1, 32'h0000_00F0, "R3");
        step(6'h01, 1'b1, 32'h8000_0001, "R3");
        // R4: drop one enable bit, others stay
        step(6'h04, 1'b1, 32'h0000_000F, "R4");
        step(6'h06, 1'b1, 32'h0000_0002, "R4");
        step(6'h04, 1'b0, '0, "R4");
        // R5: toggle alias
        step(6'h08, 1'b1, 32'hFFFF_0000, "R2");
        step(6'h0B, 1'b1, 32'h0F0F_0F0F, "R5");
        step(6'h0B, 1'b1, 32'h0F0F_0F0F, "R5");
        // R7: writing reg 1 leaves regs 0 and 2 untouched
        step(6'h05, 1'b1, 32'hDEAD_0000, "R7");
        step(6'h00, 1'b0, '0, "R7");
        // R8: read-only slot ignores writes at all aliases
        for (int k = 0; k < 4; k++) step(AW'(12 + k), 1'b1, 32'hFFFF_FFFF, "R8");
        stat_in = 32'h0BAD_F00D;
        step(6'h0E, 1'b0, '0, "R8");
        // R9: we low changes nothing; same-cycle read shows old value
        step(6'h00, 1'b0, 32'hCAFE_CAFE, "R9");
        step(6'h00, 1'b1, 32'h5555_AAAA, "R9");
        step(6'h02, 1'b0, '0, "R9");
        // R10: unmapped slots read zero and absorb writes
        step(6'h10, 1'b1, 32'h7777_7777, "R10");
        step(6'h3F, 1'b1, 32'h1111_1111, "R10");
        step(6'h13, 1'b0, '0, "R10");
        // Pseudo-random traffic
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[12] ? lfsr[5:0] : {2'b00, lfsr[3:0]}, lfsr[13],
                 {lfsr[15:0], lfsr[31:16]}, "R9");
            if (n == 200) stat_in = lfsr;
        end
        // R1: reset again after traffic
        do_reset();
        for (int s = 0; s < NRW; s++) step(AW'(s * 4 + 1), 1'b0, '0, "R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule